// File: doc/BRIEF.md
# Programmable Slot Calendar Sequencer

This block holds a per-lane schedule of up to 64 time slots. Each slot names one of 13 attached devices or marks the slot idle. During playback the block steps through the slots, one per clock, and drives that slot's owner as an encoded grant and as a one-hot grant. The schedule itself is worked out elsewhere. This block only stores the entries, takes the writes and plays them back.

Software reprograms the schedule in one pass. It raises the program-enable level. For each entry it loads a slot index, then strobes in a device code for that index. It then drops program-enable. The pass sets the schedule length to one more than the highest index written. The length is read back as length minus one. Playback is frozen and idle for the whole pass. It restarts from slot 0 once the pass closes.

Top module: `slot_cal_seq`

## Requirements
- R1: After a synchronous active-low reset, `cur_len` reads 0, `cur_slot` reads 0, `grant_code` reads 13 and `grant_onehot` is all zero on every cycle until a programming pass changes the schedule.
- R2: While `pgm_en` is high, `grant_code` is 13 and `grant_onehot` is zero from the same cycle on, and `cur_slot` reads 0 from the cycle after the first clock edge that sees `pgm_en` high.
- R3: An `idx_wr` strobe while `pgm_en` is high loads `wr_idx` as the target index. Each `val_wr` strobe while `pgm_en` is high stores `wr_val` at the target index last loaded. A second value for the same index replaces the first.
- R4: At the first clock edge that sees `pgm_en` low after a pass, `cur_len` takes the highest index written in that pass. That is the schedule length minus one. `cur_len` does not change while `pgm_en` is high. Entries not written in the pass keep their earlier contents.
- R5: A pass with no `val_wr` strobe leaves a one-slot schedule whose slot 0 holds the idle code 13, so `cur_len` reads 0.
- R6: The first cycle after a pass closes shows slot 0. After that `cur_slot` rises by one every clock and returns to 0 after slot `cur_len`. A length of one repeats slot 0 every cycle.
- R7: A slot holding code d from 0 to 12 drives `grant_code` = d and sets only bit d of `grant_onehot`. A slot holding code 13 drives `grant_code` = 13 and an all-zero `grant_onehot`.
- R8: A written value of 14 or 15 is stored as the idle code 13.
- R9: `idx_wr` and `val_wr` strobes while `pgm_en` is low change neither the stored entries, nor `cur_len`, nor the running playback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pgm_en | input | 1 | Program-enable level; high for the whole programming pass |
| idx_wr | input | 1 | Strobe that loads `wr_idx` as the target slot index |
| wr_idx | input | 6 | Slot index to load |
| val_wr | input | 1 | Strobe that stores `wr_val` at the target slot |
| wr_val | input | 4 | Device code 0..12, or 13 for idle (14 and 15 are stored as idle) |
| cur_len | output | 6 | Current schedule length minus one |
| cur_slot | output | 6 | Slot index being played this cycle |
| grant_code | output | 4 | Encoded owner of the current slot; 13 means idle |
| grant_onehot | output | 13 | One-hot owner of the current slot; all zero when idle |

## Verification
The bench aims at the length rule where it is easiest to get wrong:
- A sparse pass that writes high indices but skips low ones must take its length from the highest index. A design that counts writes would report a shorter schedule. Playback must also show the older entries that were kept.
- A pass with no writes must collapse to a single idle slot. A design that keeps the old length would go on granting the devices from before.
- A full 64-entry pass and a one-entry pass test the wrap at both extremes. An off-by-one in the pointer would show up as a skipped slot or a stray slot.

The bench also covers the write path:
- Out-of-range codes must read back as idle.
- A value strobe sent without a fresh index must land on the index loaded last.
- Strobes sent outside program mode must leave the running grant sequence exactly as it was.

// File: rtl/slot_cal_pkg.sv
// Shared constants for the slot calendar sequencer.
// Assumes one lane per instance; the sizes below are the defaults.
package slot_cal_pkg;
    localparam int unsigned CAL_DEPTH = 64;  // maximum number of slots
    localparam int unsigned CAL_NDEV  = 13;  // attached devices; code NDEV means idle
endpackage

// File: rtl/slot_cal_store.sv
// Slot entry storage and the programming-pass logic.
// What it does: latches the target index, writes the entries, tracks the
// highest index written in the pass, and commits the length when the pass closes.
// Assumes pgm_en is a level that stays high for the whole pass.
module slot_cal_store #(
    parameter  int DEPTH  = slot_cal_pkg::CAL_DEPTH,
    parameter  int NDEV   = slot_cal_pkg::CAL_NDEV,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CODE_W = $clog2(NDEV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              val_wr,
    input  logic [CODE_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  rd_ptr,
    output logic [CODE_W-1:0] rd_code,
    output logic [IDX_W-1:0]  len_m1,
    output logic              play_ok
);
    localparam logic [CODE_W-1:0] IDLE = CODE_W'(NDEV);

    logic [CODE_W-1:0] entry [DEPTH];
    logic [IDX_W-1:0]  tgt_idx;
    logic [IDX_W-1:0]  pass_max;
    logic              pass_any;
    logic              pgm_q;
    logic              closing;
    logic [CODE_W-1:0] wr_code;

    assign closing = pgm_q && !pgm_en;
    assign play_ok = !pgm_en && !pgm_q;
    assign wr_code = (wr_val > IDLE) ? IDLE : wr_val;
    assign rd_code = entry[rd_ptr];

    // Remember last cycle's program-enable, so the close of a pass can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) pgm_q <= 1'b0;
        else        pgm_q <= pgm_en;
    end

    // Hold the target index loaded by the most recent index strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                tgt_idx <= '0;
        else if (pgm_en && idx_wr) tgt_idx <= wr_idx;
    end

    // Track whether the pass wrote anything, and the highest index it wrote.
    always_ff @(posedge clk) begin
        if (!rst_n || !pgm_en) begin
            pass_any <= 1'b0;
            pass_max <= '0;
        end else if (val_wr) begin
            pass_any <= 1'b1;
            if (!pass_any || tgt_idx > pass_max) pass_max <= tgt_idx;
        end
    end

    // Commit the length (minus one) when the pass closes.
    always_ff @(posedge clk) begin
        if (!rst_n)       len_m1 <= '0;
        else if (closing) len_m1 <= pass_any ? pass_max : '0;
    end

    // One register per slot: reset to idle, written during a pass, slot 0 made idle by an empty pass.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[g] <= IDLE;
            else if (pgm_en && val_wr && tgt_idx == IDX_W'(g))
                entry[g] <= wr_code;
            else if (g == 0 && closing && !pass_any)
                entry[g] <= IDLE;
        end
    end
endmodule

// File: rtl/slot_cal_walker.sv
// Playback pointer for the slot calendar.
// What it does: holds the pointer at slot 0 while hold is high, otherwise
// steps it by one every clock and wraps it after slot len_m1.
// Assumes len_m1 changes only in a cycle in which hold is high.
module slot_cal_walker #(
    parameter  int DEPTH = slot_cal_pkg::CAL_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [IDX_W-1:0] len_m1,
    output logic [IDX_W-1:0] ptr
);
    // Step the pointer through the slots, wrapping after the last valid slot.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)   ptr <= '0;
        else if (ptr == len_m1) ptr <= '0;
        else                  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/slot_cal_grant.sv
// Grant decoder for the slot calendar.
// What it does: turns the current slot's code into an encoded grant and a
// one-hot grant, and forces both to idle when playback is not active.
// Assumes the codes 0..NDEV-1 are devices and the code NDEV means idle.
module slot_cal_grant #(
    parameter  int NDEV   = slot_cal_pkg::CAL_NDEV,
    localparam int CODE_W = $clog2(NDEV + 1)
) (
    input  logic              active,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] grant_code,
    output logic [NDEV-1:0]   grant_onehot
);
    // Encoded grant: the slot's code, or idle while playback is stopped.
    always_comb grant_code = active ? code : CODE_W'(NDEV);

    // One-hot grant: one compare per device.
    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        assign grant_onehot[d] = active && (code == CODE_W'(d));
    end
endmodule

// File: rtl/slot_cal_seq.sv
// Top level of the programmable slot calendar sequencer.
// What it does: connects the entry store, the playback walker and the grant decoder.
// Assumes synchronous active-low reset, and one programming pass at a time.
module slot_cal_seq #(
    parameter  int DEPTH  = slot_cal_pkg::CAL_DEPTH,
    parameter  int NDEV   = slot_cal_pkg::CAL_NDEV,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CODE_W = $clog2(NDEV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic              idx_wr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              val_wr,
    input  logic [CODE_W-1:0] wr_val,
    output logic [IDX_W-1:0]  cur_len,
    output logic [IDX_W-1:0]  cur_slot,
    output logic [CODE_W-1:0] grant_code,
    output logic [NDEV-1:0]   grant_onehot
);
    logic [CODE_W-1:0] slot_code;
    logic              play_ok;

    slot_cal_store #(.DEPTH(DEPTH), .NDEV(NDEV)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .pgm_en  (pgm_en),
        .idx_wr  (idx_wr),
        .wr_idx  (wr_idx),
        .val_wr  (val_wr),
        .wr_val  (wr_val),
        .rd_ptr  (cur_slot),
        .rd_code (slot_code),
        .len_m1  (cur_len),
        .play_ok (play_ok)
    );

    slot_cal_walker #(.DEPTH(DEPTH)) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (!play_ok),
        .len_m1 (cur_len),
        .ptr    (cur_slot)
    );

    slot_cal_grant #(.NDEV(NDEV)) u_grant (
        .active       (play_ok),
        .code         (slot_code),
        .grant_code   (grant_code),
        .grant_onehot (grant_onehot)
    );
endmodule

// File: rtl/slot_cal_seq_chk.sv
// Property checker for slot_cal_seq, attached with the bind statement below.
// Watches only the top-level ports, plus one register of its own for the prior program-enable.
module slot_cal_seq_chk #(
    parameter  int DEPTH  = slot_cal_pkg::CAL_DEPTH,
    parameter  int NDEV   = slot_cal_pkg::CAL_NDEV,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CODE_W = $clog2(NDEV + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pgm_en,
    input logic [IDX_W-1:0]  cur_len,
    input logic [IDX_W-1:0]  cur_slot,
    input logic [CODE_W-1:0] grant_code,
    input logic [NDEV-1:0]   grant_onehot
);
    logic prev_pgm;

    // Prior-cycle program-enable; set during reset to stay conservative.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_pgm <= 1'b1;
        else        prev_pgm <= pgm_en;
    end

    p_idle_in_pgm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |-> (grant_onehot == '0 && grant_code == CODE_W'(NDEV)));

    p_slot_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |=> cur_slot == '0);

    p_len_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_en |=> $stable(cur_len));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_en && cur_slot == cur_len) |=> cur_slot == '0);

    p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgm_en && !prev_pgm && cur_slot != cur_len) |=> cur_slot == $past(cur_slot) + 1'b1);

    p_slot_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_slot <= cur_len);

    p_onehot0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_onehot));

    p_code_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_code < CODE_W'(NDEV)) |-> grant_onehot == (NDEV'(1) << grant_code));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_code >= CODE_W'(NDEV)) |-> grant_onehot == '0);
endmodule

bind slot_cal_seq slot_cal_seq_chk #(.DEPTH(DEPTH), .NDEV(NDEV)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pgm_en       (pgm_en),
    .cur_len      (cur_len),
    .cur_slot     (cur_slot),
    .grant_code   (grant_code),
    .grant_onehot (grant_onehot)
);

// File: tb/slot_cal_seq_test.sv
// Directed bench for slot_cal_seq: one task per scenario, each checking its own results.
module slot_cal_seq_test;
    localparam int DEPTH = 64;
    localparam int NDEV  = 13;
    localparam int IDLE  = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pgm_en = 1'b0;
    logic       idx_wr = 1'b0;
    logic [5:0] wr_idx = '0;
    logic       val_wr = 1'b0;
    logic [3:0] wr_val = '0;
    logic [5:0] cur_len;
    logic [5:0] cur_slot;
    logic [3:0] grant_code;
    logic [12:0] grant_onehot;

    int n_chk = 0;
    int n_fail = 0;
    int model [DEPTH];
    int m_len_m1 = 0;
    int pass_any = 0;
    int pass_max = 0;
    int last_idx = 0;

    slot_cal_seq uut (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .idx_wr(idx_wr), .wr_idx(wr_idx),
        .val_wr(val_wr), .wr_val(wr_val), .cur_len(cur_len), .cur_slot(cur_slot),
        .grant_code(grant_code), .grant_onehot(grant_onehot)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int norm(input int v);
        return (v > IDLE) ? IDLE : v;
    endfunction

    function automatic int exp_onehot(input int code);
        return (code < NDEV) ? (1 << code) : 0;
    endfunction

    // Compare the grant outputs against an expected code.
    task automatic chk_grant(input string req, input int code);
        chk(int'(grant_code) == code, req, "grant_code", int'(grant_code), code);
        chk(int'(grant_onehot) == exp_onehot(code), req, "grant_onehot",
            int'(grant_onehot), exp_onehot(code));
    endtask

    // Watch `cycles` playback cycles, starting from whatever slot is showing now.
    task automatic play_check(input string req, input int cycles);
        int len = m_len_m1 + 1;
        int s = int'(cur_slot);
        for (int k = 0; k < cycles; k++) begin
            chk(int'(cur_slot) == s, req, "cur_slot", int'(cur_slot), s);
            chk_grant(req, model[s]);
            s = (s + 1) % len;
            @(negedge clk);
        end
    endtask

    task automatic pgm_begin();
        pgm_en = 1'b1;
        pass_any = 0;
        pass_max = 0;
        @(negedge clk);
        chk(cur_slot == 0, "R2", "slot held", int'(cur_slot), 0);
        chk_grant("R2", IDLE);
    endtask

    task automatic val_only(input int v);
        val_wr = 1'b1;
        wr_val = 4'(v);
        @(negedge clk);
        val_wr = 1'b0;
        model[last_idx] = norm(v);
        if (pass_any == 0 || last_idx > pass_max) pass_max = last_idx;
        pass_any = 1;
    endtask

    task automatic wr_entry(input int i, input int v);
        idx_wr = 1'b1;
        wr_idx = 6'(i);
        @(negedge clk);
        idx_wr = 1'b0;
        last_idx = i;
        val_only(v);
    endtask

    // Close the pass, then check the length and the restart from slot 0.
    task automatic pgm_end();
        pgm_en = 1'b0;
        if (pass_any != 0) m_len_m1 = pass_max;
        else begin
            m_len_m1 = 0;
            model[0] = IDLE;
        end
        @(negedge clk);
        chk(int'(cur_len) == m_len_m1, "R4", "cur_len", int'(cur_len), m_len_m1);
        chk(cur_slot == 0, "R6", "restart slot", int'(cur_slot), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) model[i] = IDLE;
        m_len_m1 = 0;
        last_idx = 0;
        @(negedge clk);
        chk(cur_len == 0, "R1", "cur_len", int'(cur_len), 0);
        for (int k = 0; k < 4; k++) begin
            chk(cur_slot == 0, "R1", "cur_slot", int'(cur_slot), 0);
            chk_grant("R1", IDLE);
            @(negedge clk);
        end
    endtask

    task automatic t_basic();
        int codes[5] = '{0, 5, 13, 12, 3};
        pgm_begin();
        for (int i = 0; i < 5; i++) begin
            wr_entry(i, codes[i]);
            chk_grant("R2", IDLE);
            chk(cur_len == 0, "R4", "len frozen in pass", int'(cur_len), 0);
        end
        pgm_end();
        play_check("R6 R7 basic", 12);
    endtask

    task automatic t_ignored();
        int len_before = int'(cur_len);
        idx_wr = 1'b1; wr_idx = 6'd1;
        val_wr = 1'b1; wr_val = 4'd9;
        play_check("R9 strobes low pgm", 6);
        idx_wr = 1'b0; val_wr = 1'b0;
        play_check("R9 after strobes", 6);
        chk(int'(cur_len) == len_before, "R9", "cur_len", int'(cur_len), len_before);
    endtask

    task automatic t_sparse();
        pgm_begin();
        wr_entry(7, 11);
        wr_entry(2, 6);
        pgm_end();
        chk(cur_len == 7, "R4", "highest index", int'(cur_len), 7);
        play_check("R4 kept entries", 18);
    endtask

    task automatic t_saturate();
        pgm_begin();
        wr_entry(0, 14);
        wr_entry(1, 15);
        wr_entry(2, 4);
        val_only(8);            // R3: lands on index 2 again, replacing 4
        wr_entry(3, 1);
        pgm_end();
        chk_grant("R8", IDLE);
        play_check("R8 R3 saturate overwrite", 10);
    endtask

    task automatic t_empty();
        pgm_begin();
        repeat (3) @(negedge clk);
        pgm_end();
        chk(cur_len == 0, "R5", "cur_len", int'(cur_len), 0);
        for (int k = 0; k < 5; k++) begin
            chk(cur_slot == 0, "R5", "cur_slot", int'(cur_slot), 0);
            chk_grant("R5", IDLE);
            @(negedge clk);
        end
    endtask

    task automatic t_full();
        pgm_begin();
        for (int i = 0; i < DEPTH; i++) wr_entry(i, (i * 5) % 14);
        pgm_end();
        chk(cur_len == 63, "R6", "full length", int'(cur_len), 63);
        play_check("R6 R7 full wrap", 140);
    endtask

    task automatic t_single();
        pgm_begin();
        wr_entry(0, 7);
        pgm_end();
        for (int k = 0; k < 5; k++) begin
            chk(cur_slot == 0, "R6", "single slot", int'(cur_slot), 0);
            chk_grant("R6 R7 single", 7);
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_ignored();
        t_sparse();
        t_saturate();
        t_empty();
        t_full();
        t_single();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule